// File: doc/BRIEF.md
# CAN Mailbox Event Interrupt Aggregator

This block records four kinds of per-mailbox events for a 32-mailbox CAN controller: data frame received, remote frame received, mailbox emptied and message overrun. Each event class has one sticky flag per mailbox. A per-mailbox mask and a per-mailbox direction bit decide whether an event also raises one of four summary request bits. The summary bits are ORed onto a single interrupt line. Events arrive from the rest of the controller as one-cycle pulses, one bit per mailbox.

Software reaches every flag array, the mask and the summary register through a simple register bus. Each 32-bit quantity is split into two 16-bit halves. Flags and summary bits are write-1-to-clear. The mask is plain read/write. Reads are combinational and have no side effects.

The mask only decides what reaches the summary. It never stops a per-mailbox flag from setting. A receive mailbox (direction 0) can raise the data-received, remote and overrun summaries. A transmit mailbox (direction 1) can raise only the emptied summary.

Top module: `can_mbx_irq_agg`

## Requirements
- R1: After a synchronous active-low reset, every event flag reads 0, both mask halves read 0xFFFF, the summary register reads 0 and `irq` is 0.
- R2: A pulse on bit i of any event input sets flag i of that event class at the next clock edge. This happens whatever the mask and direction of mailbox i.
- R3: Register map (4-bit address, 16-bit data): data-received flags at 0/1, remote flags at 2/3, emptied flags at 4/5, overrun flags at 6/7, mask at 8/9 (even address = mailboxes 15..0, odd address = mailboxes 31..16), summary at 10. Writing 1 to a flag bit clears it at the next edge. Writing 0 leaves it unchanged, and a write to one half never touches the other half.
- R4: If an event and a write-1 clear hit the same flag in the same cycle, the flag stays set.
- R5: The mask halves are read/write. A write replaces only the addressed half, and bit value 1 means masked.
- R6: For a mailbox with direction 0 and mask 0, an event pulse sets summary bit 0 (data received), bit 1 (remote) or bit 3 (overrun) at the next edge. With mask 1 the summary does not change, but the flag still sets.
- R7: For a mailbox with direction 1 and mask 0, an emptied pulse sets summary bit 2 at the next edge. With mask 1 that summary bit does not change.
- R8: Emptied events on receive mailboxes, and data-received, remote or overrun events on transmit mailboxes, never set a summary bit.
- R9: Summary bits are write-1-to-clear at address 10, and a set in the same cycle wins over a clear. `irq` is the OR of the four summary bits, so it is high in the cycle after an unmasked qualifying event.
- R10: Reads change no state. Addresses 11 to 15 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_rx | input | 32 | Data frame received pulses, one bit per mailbox |
| ev_rmt | input | 32 | Remote frame received pulses |
| ev_emp | input | 32 | Mailbox emptied pulses (sent or aborted) |
| ev_ovr | input | 32 | Message overrun pulses |
| mb_dir | input | 32 | Mailbox direction, 0 = receive, 1 = transmit |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_req | output | 4 | Summary bits: 0 received, 1 remote, 2 emptied, 3 overrun |
| irq | output | 1 | Interrupt line |

## Verification
The embedded assertions check the following on every cycle:
- an event always leaves its flag set, including against a simultaneous clear;
- no flag rises without an event, and none falls without a write;
- the mask resets to all ones and holds between writes;
- a masked or wrong-direction event never raises a summary bit, and `irq` rises only after some event pulse.

Only the directed scenarios can show the rest:
- the exact address decoding and half selection;
- that writing 0 is ignored;
- that masked events still leave visible flags;
- the summary clear and `irq` fall;
- that unmapped addresses neither read nor store anything.

// File: rtl/can_irq_pkg.sv
// Package: shared constants for the CAN mailbox interrupt aggregator.
// Assumes four event classes in a fixed order; summary bit positions follow
// the class index.
package can_irq_pkg;
    localparam int NUM_EV = 4;
    localparam int EV_RX  = 0;   // data frame received
    localparam int EV_RMT = 1;   // remote frame received
    localparam int EV_EMP = 2;   // mailbox emptied
    localparam int EV_OVR = 3;   // message overrun
endpackage

// File: rtl/mbx_flag_bank.sv
// Module: one array of sticky per-mailbox event flags.
// Flags set on event pulses and clear on write-1 to the addressed half.
// A set in the same cycle as a clear wins.
// Assumes NUM_MB is a multiple of REG_W and spans at least two halves.
module mbx_flag_bank #(
    parameter int NUM_MB = 32,
    parameter int REG_W  = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_MB-1:0]                   set_i,
    input  logic                                wr_en,
    input  logic [$clog2(NUM_MB/REG_W)-1:0]     wr_half,
    input  logic [REG_W-1:0]                    wdata,
    output logic [NUM_MB-1:0]                   flags_o
);
    localparam int NUM_HALF  = NUM_MB / REG_W;
    localparam int HALF_BITS = $clog2(NUM_HALF);

    logic [NUM_MB-1:0] clr;

    // Build the clear vector: only the addressed half sees the write data.
    for (genvar h = 0; h < NUM_HALF; h++) begin : g_clr
        assign clr[h*REG_W +: REG_W] =
            (wr_en && wr_half == HALF_BITS'(h)) ? wdata : '0;
    end

    // Flag register: clear by write-1, then apply sets so that a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (flags_o & ~clr) | set_i;
    end

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    assert_rise_needs_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((flags_o & ~$past(flags_o) & ~$past(set_i)) == '0));

    assert_clear_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((~flags_o & $past(flags_o)) == '0));
endmodule

// File: rtl/mbx_mask_reg.sv
// Module: per-mailbox interrupt mask, split into REG_W-bit halves.
// Resets to all ones (everything masked). A write replaces only the
// addressed half. Assumes NUM_MB is a multiple of REG_W.
module mbx_mask_reg #(
    parameter int NUM_MB = 32,
    parameter int REG_W  = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [$clog2(NUM_MB/REG_W)-1:0]     wr_half,
    input  logic [REG_W-1:0]                    wdata,
    output logic [NUM_MB-1:0]                   mask_o
);
    localparam int NUM_HALF  = NUM_MB / REG_W;
    localparam int HALF_BITS = $clog2(NUM_HALF);

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        // Half register: reset masked, load on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_o[h*REG_W +: REG_W] <= '1;
            else if (wr_en && wr_half == HALF_BITS'(h))
                mask_o[h*REG_W +: REG_W] <= wdata;
        end
    end

    assert_mask_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (&mask_o));

    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_o));
endmodule

// File: rtl/mbx_irq_summary.sv
// Module: folds per-mailbox events into NUM_EV sticky summary request bits.
// Receive-class events count only on unmasked receive mailboxes. Emptied
// events count only on unmasked transmit mailboxes. Bits are write-1-to-clear,
// and a set wins over a clear in the same cycle.
module mbx_irq_summary
    import can_irq_pkg::*;
#(
    parameter int NUM_MB = 32,
    parameter int REG_W  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_EV-1:0][NUM_MB-1:0]  ev_vec,
    input  logic [NUM_MB-1:0]              mb_dir,
    input  logic [NUM_MB-1:0]              mask,
    input  logic                           wr_en,
    input  logic [REG_W-1:0]               wdata,
    output logic [NUM_EV-1:0]              req_o
);
    logic [NUM_MB-1:0] rx_open;
    logic [NUM_MB-1:0] tx_open;
    logic [NUM_EV-1:0] hit;
    logic [NUM_EV-1:0] clr;

    // Qualifying windows: unmasked mailboxes split by direction.
    always_comb begin
        rx_open = ~mask & ~mb_dir;
        tx_open = ~mask & mb_dir;
    end

    // Per class: emptied uses transmit mailboxes, the others use receive ones.
    for (genvar e = 0; e < NUM_EV; e++) begin : g_hit
        if (e == EV_EMP) begin : g_tx
            assign hit[e] = |(ev_vec[e] & tx_open);
        end else begin : g_rx
            assign hit[e] = |(ev_vec[e] & rx_open);
        end
    end

    assign clr = wr_en ? wdata[NUM_EV-1:0] : '0;

    // Summary register: clear by write-1, then apply hits so that a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= '0;
        else        req_o <= (req_o & ~clr) | hit;
    end

    assert_masked_rx_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_vec[EV_RX] & ~mask & ~mb_dir) == '0) |=> !(req_o[EV_RX] && !$past(req_o[EV_RX])));

    assert_masked_emp_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_vec[EV_EMP] & ~mask & mb_dir) == '0) |=> !(req_o[EV_EMP] && !$past(req_o[EV_EMP])));

    assert_tx_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_vec[EV_OVR] & ~mb_dir) == '0) |=> !(req_o[EV_OVR] && !$past(req_o[EV_OVR])));

    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((req_o & $past(hit)) == $past(hit)));
endmodule

// File: rtl/can_mbx_irq_agg.sv
// Module: top of the CAN mailbox event interrupt aggregator.
// Holds four flag banks, the mask and the summary, and decodes the register
// bus. Address = {class, half}: the flag classes come first, then the mask,
// then the summary at half 0. Reads are combinational with no side effects.
// Assumes NUM_MB / REG_W >= 2 and enough address bits for the whole map.
module can_mbx_irq_agg
    import can_irq_pkg::*;
#(
    parameter int NUM_MB = 32,
    parameter int REG_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_MB-1:0] ev_rx,
    input  logic [NUM_MB-1:0] ev_rmt,
    input  logic [NUM_MB-1:0] ev_emp,
    input  logic [NUM_MB-1:0] ev_ovr,
    input  logic [NUM_MB-1:0] mb_dir,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NUM_EV-1:0] irq_req,
    output logic              irq
);
    localparam int NUM_HALF  = NUM_MB / REG_W;
    localparam int HALF_BITS = $clog2(NUM_HALF);
    localparam int MASK_BASE = NUM_EV * NUM_HALF;
    localparam int SUM_ADDR  = (NUM_EV + 1) * NUM_HALF;

    logic [NUM_EV-1:0][NUM_MB-1:0] ev_all;
    logic [NUM_EV-1:0][NUM_MB-1:0] flags_all;
    logic [NUM_MB-1:0]             mask;
    logic [ADDR_W-1:0]             kind;
    logic [HALF_BITS-1:0]          half;

    assign ev_all[EV_RX]  = ev_rx;
    assign ev_all[EV_RMT] = ev_rmt;
    assign ev_all[EV_EMP] = ev_emp;
    assign ev_all[EV_OVR] = ev_ovr;

    assign kind = bus_addr >> HALF_BITS;
    assign half = bus_addr[HALF_BITS-1:0];

    for (genvar k = 0; k < NUM_EV; k++) begin : g_bank
        mbx_flag_bank #(.NUM_MB(NUM_MB), .REG_W(REG_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (ev_all[k]),
            .wr_en   (bus_wr && kind == ADDR_W'(k)),
            .wr_half (half),
            .wdata   (bus_wdata),
            .flags_o (flags_all[k])
        );
    end

    mbx_mask_reg #(.NUM_MB(NUM_MB), .REG_W(REG_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && kind == ADDR_W'(NUM_EV)),
        .wr_half (half),
        .wdata   (bus_wdata),
        .mask_o  (mask)
    );

    mbx_irq_summary #(.NUM_MB(NUM_MB), .REG_W(REG_W)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_vec (ev_all),
        .mb_dir (mb_dir),
        .mask   (mask),
        .wr_en  (bus_wr && bus_addr == ADDR_W'(SUM_ADDR)),
        .wdata  (bus_wdata),
        .req_o  (irq_req)
    );

    assign irq = |irq_req;

    // Read mux: flag halves, then mask halves, then the summary; others read 0.
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_EV; k++)
            for (int h = 0; h < NUM_HALF; h++)
                if (bus_addr == ADDR_W'(k * NUM_HALF + h))
                    bus_rdata = flags_all[k][h*REG_W +: REG_W];
        for (int h = 0; h < NUM_HALF; h++)
            if (bus_addr == ADDR_W'(MASK_BASE + h))
                bus_rdata = mask[h*REG_W +: REG_W];
        if (bus_addr == ADDR_W'(SUM_ADDR))
            bus_rdata = REG_W'(irq_req);
    end

    assert_irq_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|{ev_rx, ev_rmt, ev_emp, ev_ovr}));

    assert_mask_keeps_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev_rx & mask)) |=> ((flags_all[EV_RX] & $past(ev_rx & mask)) == $past(ev_rx & mask)));
endmodule

// File: tb/tb_can_mbx_irq_agg.sv
// Directed bench: one task per scenario. Inputs change on the falling edge,
// and results are read on the falling edge after the active edge.
module tb_can_mbx_irq_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ev_rx = '0, ev_rmt = '0, ev_emp = '0, ev_ovr = '0, mb_dir = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  irq_req;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;   // 125 MHz

    can_mbx_irq_agg dut (
        .clk(clk), .rst_n(rst_n), .ev_rx(ev_rx), .ev_rmt(ev_rmt),
        .ev_emp(ev_emp), .ev_ovr(ev_ovr), .mb_dir(mb_dir),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_req(irq_req), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd_check(input string tag, input logic [3:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        check(tag, {16'h0, bus_rdata}, {16'h0, exp});
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    // Pulse one event class (0 rx, 1 remote, 2 emptied, 3 overrun) on one mailbox.
    task automatic pulse(input int cls, input int mb);
        case (cls)
            0: ev_rx[mb]  = 1'b1;
            1: ev_rmt[mb] = 1'b1;
            2: ev_emp[mb] = 1'b1;
            default: ev_ovr[mb] = 1'b1;
        endcase
        tick();
        ev_rx = '0; ev_rmt = '0; ev_emp = '0; ev_ovr = '0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd_check("R1 flag reset", 4'(a), 16'h0000);
        rd_check("R1 mask lo reset", 4'd8, 16'hFFFF);
        rd_check("R1 mask hi reset", 4'd9, 16'hFFFF);
        rd_check("R1 summary reset", 4'd10, 16'h0000);
        check("R1 irq reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_event_set();
        mb_dir = '0;
        pulse(0, 5);
        pulse(0, 20);
        rd_check("R2 rx flag lo", 4'd0, 16'h0020);
        rd_check("R2 rx flag hi", 4'd1, 16'h0010);
        pulse(2, 31);   // emptied event on a masked receive mailbox
        rd_check("R2 emp flag any direction", 4'd5, 16'h8000);
        check("R2 masked no irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_w1c();
        wr(4'd0, 16'h0000);
        rd_check("R3 write 0 ignored", 4'd0, 16'h0020);
        wr(4'd0, 16'hFFDF);
        rd_check("R3 other bits only", 4'd0, 16'h0020);
        wr(4'd0, 16'h0020);
        rd_check("R3 w1c clears", 4'd0, 16'h0000);
        rd_check("R3 other half kept", 4'd1, 16'h0010);
        wr(4'd1, 16'h0010);
        rd_check("R3 hi cleared", 4'd1, 16'h0000);
        wr(4'd5, 16'h8000);
        rd_check("R3 emp cleared", 4'd5, 16'h0000);
    endtask

    task automatic t_set_wins();
        pulse(1, 3);
        rd_check("R4 rmt flag set", 4'd2, 16'h0008);
        ev_rmt[3] = 1'b1;
        wr(4'd2, 16'h0008);
        ev_rmt = '0;
        rd_check("R4 set beats clear", 4'd2, 16'h0008);
        wr(4'd2, 16'h0008);
        rd_check("R4 later clear", 4'd2, 16'h0000);
    endtask

    task automatic t_mask_rw();
        wr(4'd8, 16'h00F0);
        rd_check("R5 mask lo write", 4'd8, 16'h00F0);
        rd_check("R5 mask hi kept", 4'd9, 16'hFFFF);
        wr(4'd9, 16'h0000);
        rd_check("R5 mask hi write", 4'd9, 16'h0000);
        rd_check("R5 mask lo kept", 4'd8, 16'h00F0);
        wr(4'd8, 16'hFFFF);
        wr(4'd9, 16'hFFFF);
    endtask

    task automatic t_rx_gate();
        mb_dir = '0;
        wr(4'd8, 16'hFFFB);        // unmask mailbox 2
        pulse(0, 2);
        rd_check("R6 rx summary", 4'd10, 16'h0001);
        check("R6 irq up", {31'h0, irq}, 32'h1);
        pulse(1, 7);               // masked mailbox
        rd_check("R6 masked rmt no summary", 4'd10, 16'h0001);
        rd_check("R6 masked rmt flag set", 4'd2, 16'h0080);
        pulse(3, 2);
        rd_check("R6 ovr summary", 4'd10, 16'h0009);
        pulse(1, 2);
        rd_check("R6 rmt summary", 4'd10, 16'h000B);
        wr(4'd10, 16'h000F);
        rd_check("R9 summary cleared", 4'd10, 16'h0000);
        check("R9 irq down", {31'h0, irq}, 32'h0);
        for (int a = 0; a < 8; a++) wr(4'(a), 16'hFFFF);
    endtask

    task automatic t_tx_gate();
        mb_dir = 32'h0004_0000;   // mailbox 18 transmits
        wr(4'd9, 16'hFFFB);       // unmask mailbox 18
        pulse(2, 18);
        rd_check("R7 emp summary", 4'd10, 16'h0004);
        wr(4'd10, 16'h0004);
        pulse(2, 2);              // receive mailbox, unmasked
        rd_check("R8 emp on rx no summary", 4'd10, 16'h0000);
        pulse(0, 18);             // transmit mailbox, unmasked
        rd_check("R8 rx on tx no summary", 4'd10, 16'h0000);
        wr(4'd9, 16'hFFFF);
        pulse(2, 18);
        rd_check("R7 masked emp no summary", 4'd10, 16'h0000);
        rd_check("R7 masked emp flag set", 4'd5, 16'h0004);
        check("R7 irq stays low", {31'h0, irq}, 32'h0);
        for (int a = 0; a < 8; a++) wr(4'(a), 16'hFFFF);
        mb_dir = '0;
    endtask

    task automatic t_sum_clear();
        ev_rx[2] = 1'b1;
        #1;
        check("R9 irq not before edge", {31'h0, irq}, 32'h0);
        tick();
        ev_rx = '0;
        check("R9 irq after edge", {31'h0, irq}, 32'h1);
        wr(4'd10, 16'h0000);
        rd_check("R9 write 0 ignored", 4'd10, 16'h0001);
        ev_rx[2] = 1'b1;
        wr(4'd10, 16'h0001);
        ev_rx = '0;
        rd_check("R9 set beats clear", 4'd10, 16'h0001);
        wr(4'd10, 16'h0001);
        rd_check("R9 cleared", 4'd10, 16'h0000);
        for (int a = 0; a < 8; a++) wr(4'(a), 16'hFFFF);
    endtask

    task automatic t_unmapped();
        for (int a = 11; a < 16; a++) wr(4'(a), 16'hFFFF);
        for (int a = 11; a < 16; a++) rd_check("R10 unmapped reads 0", 4'(a), 16'h0000);
        rd_check("R10 mask untouched", 4'd8, 16'hFFFB);
        rd_check("R10 summary untouched", 4'd10, 16'h0000);
        pulse(0, 0);
        rd_check("R10 first read", 4'd0, 16'h0001);
        tick();
        rd_check("R10 read has no side effect", 4'd0, 16'h0001);
    endtask

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_event_set();
        t_w1c();
        t_set_wins();
        t_mask_rw();
        t_rx_gate();
        t_tx_gate();
        t_sum_clear();
        t_unmapped();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule